// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz tick strobe into periodic interrupt events for a real-time-clock register block. A 4-bit rate code selects a period that is a power of two, measured in 32 kHz ticks. Each event produces three outputs:

- a one-cycle OR-mask for the flag register, setting the periodic flag and the summary interrupt flag;
- a one-cycle interrupt pulse;
- a one-cycle square-wave pulse, when that output is enabled.

A free-running tick counter runs from reset whether or not the timer is enabled. Events fall on multiples of the period on that counter, not on the moment the timer was switched on. The timer runs only while the rate code is nonzero and the periodic interrupt enable is set.

When the rate code or the enable changes, the next event moves to the next multiple of the new period beyond the current count. The register block above this one holds the enables and the rate field. It ORs the mask into its flag register and clears that register when the flags are read.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset, all outputs are low and the tick counter is zero, so the first tick after reset brings the count to 1.
- R2: Rate code 0 produces no event, whatever the state of the enables.
- R3: With the periodic interrupt enable low, no event is produced: the flag mask, interrupt and square-wave outputs stay low.
- R4: For rate codes 3 to 15, the period is 2^(code-1) ticks, so code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: Rate code 1 gives the period of code 8 (128 ticks), and rate code 2 gives the period of code 9 (256 ticks).
- R6: The 15-bit tick counter advances by one on every tick and wraps after 32767. An event fires on a tick whose new count value is a multiple of the period. After the timer is enabled, the first event is therefore at the next multiple beyond the current count.
- R7: At each event, `flag_set` equals 8'hC0 (bits 7 and 6 set) for exactly one clock cycle. It is 8'h00 at all other times.
- R8: `irq_pulse` is high for exactly one clock cycle at each event.
- R9: `sqw_pulse` is high for one cycle at an event only when `sqw_en` is set. It is never a sustained level.
- R10: The outputs for an event are high in the clock cycle right after the rising edge that sampled `tick_32k` high.
- R11: A change of rate code while running takes effect at once: the next event falls on the next multiple of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle strobe at 32.768 kHz |
| rate_code | input | 4 | Rate-select code; 0 disables the timer |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse output enable |
| flag_set | output | 8 | One-cycle OR-mask for the flag register (8'hC0 at an event) |
| irq_pulse | output | 1 | One-cycle interrupt request at each event |
| sqw_pulse | output | 1 | One-cycle square-wave pulse at each enabled event |

## Verification
Each event result is due in the cycle after the rising edge that sampled the tick high. The bench raises the tick for one cycle, drops it, and samples at the falling edge that follows, so it reads exactly that cycle. At the falling edge one cycle later, just before the next tick is raised, it requires all outputs to be low again, which checks that each pulse lasts a single cycle. The expected event on each tick comes from the bench's own count of the ticks it has issued since reset, tested against the period derived from the rate code. Rate and enable changes are applied only between ticks.

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int          CNT_W     = 15,
  parameter int          CODE_W    = 4,
  parameter logic [7:0]  FLAG_BITS = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic [7:0]        flag_set,
  output logic              irq_pulse,
  output logic              sqw_pulse
);

  localparam logic [CODE_W-1:0] REMAP_ADD = CODE_W'(7);

  logic [CNT_W-1:0]  tick_cnt;
  logic [CNT_W-1:0]  cnt_next;
  logic [CODE_W-1:0] eff_code;
  logic [CNT_W:0]    period_bit;
  logic [CNT_W-1:0]  period_mask;
  logic              running;
  logic              fire;

  assign eff_code    = (rate_code == CODE_W'(1) || rate_code == CODE_W'(2))
                       ? rate_code + REMAP_ADD : rate_code;
  assign period_bit  = (CNT_W+1)'(1) << (eff_code - CODE_W'(1));
  assign period_mask = period_bit[CNT_W-1:0] - CNT_W'(1);
  assign running     = pie_en && (rate_code != '0);
  assign cnt_next    = tick_cnt + CNT_W'(1);
  assign fire        = tick_32k && running && ((cnt_next & period_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt  <= '0;
      flag_set  <= '0;
      irq_pulse <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      if (tick_32k) tick_cnt <= cnt_next;
      flag_set  <= fire ? FLAG_BITS : 8'h00;
      irq_pulse <= fire;
      sqw_pulse <= fire && sqw_en;
    end
  end

endmodule

// File: rtl/rtc_periodic_gen_chk.sv
module rtc_periodic_gen_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_32k,
  input logic [CODE_W-1:0] rate_code,
  input logic              pie_en,
  input logic              sqw_en,
  input logic [7:0]        flag_set,
  input logic              irq_pulse,
  input logic              sqw_pulse
);

  p_code0_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != 8'h00) |-> $past(rate_code != '0));

  p_pie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(pie_en));

  p_flag_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != 8'h00) |-> (flag_set == 8'hC0 && irq_pulse));

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  p_sqw_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> ($past(sqw_en) && irq_pulse));

  p_sqw_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |=> !sqw_pulse);

  p_tick_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(tick_32k));

endmodule

bind rtc_periodic_gen rtc_periodic_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
  .pie_en(pie_en), .sqw_en(sqw_en), .flag_set(flag_set),
  .irq_pulse(irq_pulse), .sqw_pulse(sqw_pulse)
);

// File: tb/tb_rtc_periodic_gen.sv
module tb_rtc_periodic_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic [7:0] flag_set;
  logic       irq_pulse;
  logic       sqw_pulse;

  int errors = 0;
  int checks = 0;
  int bcnt   = 0;
  int cycles = 0;
  int events_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_periodic_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
    .pie_en(pie_en), .sqw_en(sqw_en), .flag_set(flag_set),
    .irq_pulse(irq_pulse), .sqw_pulse(sqw_pulse)
  );

  function automatic int period_of(input int code);
    int e;
    e = (code == 1 || code == 2) ? code + 7 : code;
    return 1 << (e - 1);
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual flags=%h irq=%b sqw=%b expected flags=%h irq=%b sqw=%b",
               req, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic do_tick(input string req);
    bit ev;
    @(negedge clk);
    check({req, "/R8 pulse dropped"}, {flag_set, irq_pulse, sqw_pulse}, 10'd0);
    tick_32k = 1'b1;
    @(negedge clk);
    tick_32k = 1'b0;
    bcnt = (bcnt + 1) & 32'h7fff;
    ev = pie_en && (rate_code != 0) && ((bcnt % period_of(int'(rate_code))) == 0);
    if (ev) events_seen++;
    check(req, {flag_set, irq_pulse, sqw_pulse},
          ev ? {8'hC0, 1'b1, sqw_en} : 10'd0);
  endtask

  task automatic run_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) do_tick(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bcnt = 0;
    @(negedge clk);
    check("R1 reset outputs", {flag_set, irq_pulse, sqw_pulse}, 10'd0);
  endtask

  task automatic t_first_event_after_reset;
    rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b1;
    events_seen = 0;
    run_ticks(3, "R1 count from zero");
    checks++;
    if (events_seen != 0) begin
      errors++;
      $display("FAIL R1: actual events=%0d expected events=0 in first 3 ticks", events_seen);
    end
    do_tick("R1/R10 event at 4th tick");
    checks++;
    if (events_seen != 1) begin
      errors++;
      $display("FAIL R10: actual events=%0d expected events=1", events_seen);
    end
  endtask

  task automatic t_code0;
    rate_code = 4'd0; pie_en = 1'b1; sqw_en = 1'b1;
    run_ticks(64, "R2 code 0 silent");
  endtask

  task automatic t_pie_off;
    rate_code = 4'd3; pie_en = 1'b0; sqw_en = 1'b1;
    run_ticks(40, "R3 pie off silent");
  endtask

  task automatic t_sweep;
    sqw_en = 1'b1; pie_en = 1'b1;
    for (int c = 3; c <= 15; c++) begin
      rate_code = 4'(c);
      run_ticks((c <= 12) ? 2 * period_of(c) : period_of(c) + 1, "R4/R6 period sweep");
    end
  endtask

  task automatic t_remap;
    pie_en = 1'b1; sqw_en = 1'b0;
    rate_code = 4'd1;
    run_ticks(2 * 128, "R5 code 1 as 128 ticks, R9 sqw disabled");
    rate_code = 4'd2;
    run_ticks(2 * 256, "R5 code 2 as 256 ticks, R9 sqw disabled");
  endtask

  task automatic t_reschedule;
    pie_en = 1'b1; sqw_en = 1'b1;
    rate_code = 4'd6;
    while ((bcnt % 32) != 13) do_tick("R11 align");
    rate_code = 4'd3;
    run_ticks(20, "R11 rate change");
    pie_en = 1'b0;
    run_ticks(5, "R3 disable");
    pie_en = 1'b1;
    rate_code = 4'd5;
    run_ticks(40, "R6 enable mid-period");
  endtask

  task automatic t_gap_between_ticks;
    pie_en = 1'b1; sqw_en = 1'b1; rate_code = 4'd3;
    while ((bcnt % 4) != 3) do_tick("R10 align");
    do_tick("R7 event");
    repeat (4) begin
      @(negedge clk);
      check("R7/R9 quiet without tick", {flag_set, irq_pulse, sqw_pulse}, 10'd0);
    end
  endtask

  initial begin
    t_reset();
    t_first_event_after_reset();
    t_code0();
    t_pie_off();
    t_remap();
    t_reschedule();
    t_gap_between_ticks();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule